// File: doc/BRIEF.md
# Completion Packet Readout Register Port

This block takes completion packets from a receive path and holds them until software collects them over a small word-addressed register bus. Each packet is a run of 32-bit dwords. The first dword carries a start marker and the last dword carries an end marker. As dwords arrive, the block packs them into pairs and queues the pairs in an internal FIFO. Software polls a status word until the start flag is set. It then reads two data registers, once per pair, and checks the end flag before each pair to know when the packet finishes.

The same register port also holds a five-bit interrupt status word. One bit latches the arrival of a complete completion packet, and four bits latch pulses on the legacy interrupt lines D, C, B and A. Software clears these bits by writing ones to them. A five-bit enable word masks the status bits onto a single interrupt output. Only the completion path and the four legacy lines can set status bits, so message-signalled interrupts, which travel as ordinary memory writes, never reach this logic.

Top module: `cplq_regport`

## Requirements
- R1: After reset, the status, interrupt status and enable registers read 0, `irq` is 0 and `rx_ready` is 1.
- R2: Status bit 0 (start flag) reads 1 only when the pair at the head of the queue is the first pair of a packet. When the queue is empty, it reads 0 and both data registers read 0 without changing any state.
- R3: At word offsets 1 and 2, the data registers return the low dword (even index) and high dword (odd index) of the head pair. Only a read of offset 2 advances to the next pair, and repeated reads of offset 1 return the same dword.
- R4: Status bit 1 (end flag) reads 1 exactly when the head pair holds the final dword of its packet. Pairs are returned in arrival order, two dwords per pair.
- R5: For a packet with an odd dword count, the high dword of the final pair reads as 0.
- R6: Interrupt status (offset 3) bit 4 is set when the final dword of a packet is accepted. Bits 3, 2, 1 and 0 are set by pulses on `intx_evt[3]`, `[2]`, `[1]` and `[0]` (lines D, C, B, A).
- R7: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged. A bit whose set event comes in the same cycle as its clear stays set.
- R8: Interrupt status bits 31:5 always read 0. The enable register (offset 4) stores and returns only bits 4:0.
- R9: `irq` is 1 exactly when some interrupt status bit and its enable bit are both 1.
- R10: `rx_ready` is 0 while the queue holds FIFO_PAIRS pairs, and a dword presented while `rx_ready` is 0 is not stored.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. In any cycle without a read, and for unmapped offsets, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive dword valid |
| rx_data | input | 32 | Receive dword |
| rx_sop | input | 1 | Dword is the first of a packet |
| rx_eop | input | 1 | Dword is the last of a packet |
| rx_ready | output | 1 | Block can accept a dword |
| intx_evt | input | 4 | Legacy interrupt pulses, [3]=D down to [0]=A |
| bus_addr | input | 3 | Register word offset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after the strobe |
| irq | output | 1 | Masked interrupt output |

## Verification
A bad packing state, such as a dropped held low dword or a wrong end flag on a pair, shows up on the very next status or data read as a shifted dword, a missing zero in the odd slot, or an end flag on the wrong pair. A queue pointer fault shows up either as data read back in the wrong order or as `rx_ready` dropping at the wrong fill level. Both are visible within one packet drain. An interrupt latch fault appears on `irq` in the cycle after the triggering event or write, and on the interrupt status word at the next read.

// File: rtl/cplq_pkg.sv
package cplq_pkg;
   localparam int DW = 32;
   localparam int NSRC = 5;

   localparam int OFF_STATUS = 0;
   localparam int OFF_DATA_LO = 1;
   localparam int OFF_DATA_HI = 2;
   localparam int OFF_ISTAT = 3;
   localparam int OFF_IEN = 4;

   typedef struct packed {
      logic          first;
      logic          last;
      logic [DW-1:0] hi;
      logic [DW-1:0] lo;
   } pair_t;

   localparam int PAIR_W = $bits(pair_t);
endpackage

// File: rtl/cplq_packer.sv
module cplq_packer
   import cplq_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_sop,
   input  logic          rx_eop,
   input  logic          q_full,
   output logic          rx_ready,
   output logic          push,
   output pair_t         push_pair,
   output logic          pkt_done
);
   logic          held_v;
   logic [DW-1:0] held_lo;
   logic          held_first;
   logic          take;

   assign rx_ready = !q_full;
   assign take     = rx_valid && rx_ready;
   assign push     = take && (held_v || rx_eop);
   assign pkt_done = take && rx_eop;

   always_comb begin
      if (held_v) begin
         push_pair.first = held_first;
         push_pair.last  = rx_eop;
         push_pair.hi    = rx_data;
         push_pair.lo    = held_lo;
      end else begin
         push_pair.first = rx_sop;
         push_pair.last  = 1'b1;
         push_pair.hi    = '0;
         push_pair.lo    = rx_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_v     <= 1'b0;
         held_lo    <= '0;
         held_first <= 1'b0;
      end else if (take) begin
         if (held_v) begin
            held_v <= 1'b0;
         end else if (!rx_eop) begin
            held_v     <= 1'b1;
            held_lo    <= rx_data;
            held_first <= rx_sop;
         end
      end
   end
endmodule

// File: rtl/cplq_fifo.sv
module cplq_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 66
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("cplq_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push && wp == PW'(i)) mem[i] <= wdata;
         end
      end
   endgenerate

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R10
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R2
endmodule

// File: rtl/cplq_irq_regs.sv
module cplq_irq_regs #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic         en_we,
   input  logic [N-1:0] en_wdata,
   output logic [N-1:0] stat,
   output logic [N-1:0] en,
   output logic         irq
);
   initial begin
      if (N < 1) $error("cplq_irq_regs: N must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     en <= '0;
      else if (en_we) en <= en_wdata;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)      stat[i] <= 1'b0;
            else if (set[i]) stat[i] <= 1'b1;
            else if (clr[i]) stat[i] <= 1'b0;
         end

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> stat[i]); // R7
         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !stat[i]); // R7
      end
   endgenerate

   assign irq = |(stat & en);
endmodule

// File: rtl/cplq_regport.sv
module cplq_regport
   import cplq_pkg::*;
#(
   parameter int FIFO_PAIRS = 4,
   parameter int ADDR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DW-1:0]     rx_data,
   input  logic              rx_sop,
   input  logic              rx_eop,
   output logic              rx_ready,
   input  logic [3:0]        intx_evt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   initial begin
      if (ADDR_W < 3) $error("cplq_regport: ADDR_W must cover five offsets");
   end

   logic          push, pop, q_empty, q_full, pkt_done;
   pair_t         push_pair, head;
   logic [NSRC-1:0] istat, ien, clr;
   logic          sel_status, sel_lo, sel_hi, sel_istat, sel_ien;
   logic [DW-1:0] rd_mux;

   assign sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
   assign sel_lo     = (bus_addr == ADDR_W'(OFF_DATA_LO));
   assign sel_hi     = (bus_addr == ADDR_W'(OFF_DATA_HI));
   assign sel_istat  = (bus_addr == ADDR_W'(OFF_ISTAT));
   assign sel_ien    = (bus_addr == ADDR_W'(OFF_IEN));

   cplq_packer u_pack (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sop(rx_sop), .rx_eop(rx_eop), .q_full(q_full), .rx_ready(rx_ready),
      .push(push), .push_pair(push_pair), .pkt_done(pkt_done)
   );

   cplq_fifo #(.DEPTH(FIFO_PAIRS), .W(PAIR_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_pair),
      .pop(pop), .head(head), .empty(q_empty), .full(q_full)
   );

   assign pop = bus_rd && sel_hi && !q_empty;
   assign clr = (bus_wr && sel_istat) ? bus_wdata[NSRC-1:0] : '0;

   cplq_irq_regs #(.N(NSRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .set({pkt_done, intx_evt}), .clr(clr),
      .en_we(bus_wr && sel_ien), .en_wdata(bus_wdata[NSRC-1:0]),
      .stat(istat), .en(ien), .irq(irq)
   );

   always_comb begin
      rd_mux = '0;
      if (sel_status)     rd_mux = DW'({head.last && !q_empty, head.first && !q_empty});
      else if (sel_lo)    rd_mux = q_empty ? '0 : head.lo;
      else if (sel_hi)    rd_mux = q_empty ? '0 : head.hi;
      else if (sel_istat) rd_mux = DW'(istat);
      else if (sel_ien)   rd_mux = DW'(ien);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (sel_lo || sel_hi) && q_empty) |=> (bus_rdata == '0)); // R2
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_istat) |=> (bus_rdata[DW-1:NSRC] == '0)); // R8
   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R11
endmodule

// File: tb/cplq_regport_tb.sv
module cplq_regport_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
   logic [31:0] rx_data = '0;
   logic        rx_ready;
   logic [3:0]  intx_evt = '0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cplq_regport u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_ready(rx_ready), .intx_evt(intx_evt),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam int NV = 6;
   localparam int unsigned LENS [NV] = '{1, 2, 3, 4, 5, 7};
   localparam logic [31:0] BASES [NV] = '{32'hA000_0000, 32'hB100_0010,
      32'hC200_0020, 32'hD300_0030, 32'hE400_0040, 32'hF500_0050};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic send(input logic [31:0] d, input logic s, input logic e);
      @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_sop = s; rx_eop = e;
      @(negedge clk); rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
   endtask

   task automatic pulse_intx(input logic [3:0] v);
      @(negedge clk); intx_evt = v;
      @(negedge clk); intx_evt = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rx_ready", 32'(rx_ready), 32'd1);
      chk("R1 irq", 32'(irq), 32'd0);
      rd(3'd0, d); chk("R1 status", d, 32'd0);
      rd(3'd3, d); chk("R1 istat", d, 32'd0);
      rd(3'd4, d); chk("R1 ien", d, 32'd0);

      // R2 empty queue reads
      rd(3'd1, d); chk("R2 empty lo", d, 32'd0);
      rd(3'd2, d); chk("R2 empty hi", d, 32'd0);
      rd(3'd0, d); chk("R2 empty status", d, 32'd0);

      // vector walk: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         int len = int'(LENS[v]);
         int np = (len + 1) / 2;
         for (int i = 0; i < len; i++)
            send(BASES[v] + 32'(i), i == 0, i == len - 1);
         for (int p = 0; p < np; p++) begin
            rd(3'd0, d);
            chk("R2 R4 status flags", d, {30'd0, p == np - 1, p == 0});
            rd(3'd1, d); chk("R3 low dword", d, BASES[v] + 32'(2 * p));
            if (p == 0) begin
               rd(3'd1, d); chk("R3 low reread", d, BASES[v]);
            end
            rd(3'd2, d);
            if (2 * p + 1 < len) chk("R3 high dword", d, BASES[v] + 32'(2 * p + 1));
            else                 chk("R5 odd tail zero", d, 32'd0);
         end
         rd(3'd0, d); chk("R4 drained", d, 32'd0);
      end

      rd(3'd3, d); chk("R6 completion bit", d, 32'h10);
      wr(3'd3, 32'h0); rd(3'd3, d); chk("R7 write zero keeps", d, 32'h10);
      wr(3'd3, 32'h10); rd(3'd3, d); chk("R7 w1c clears", d, 32'h0);

      pulse_intx(4'b0101);
      rd(3'd3, d); chk("R6 legacy C A", d, 32'h05);
      chk("R9 irq masked", 32'(irq), 32'd0);
      wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); chk("R8 enable width", d, 32'h1F);
      chk("R9 irq on", 32'(irq), 32'd1);
      wr(3'd4, 32'h02);
      chk("R9 irq off", 32'(irq), 32'd0);
      pulse_intx(4'b0010);
      chk("R9 irq line B", 32'(irq), 32'd1);

      // R7 set in same cycle as clear
      @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h02; intx_evt = 4'b0010;
      @(negedge clk); bus_wr = 1'b0; intx_evt = '0;
      rd(3'd3, d); chk("R7 set wins", d, 32'h07);
      wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R8 all clear reserved zero", d, 32'h0);
      chk("R9 irq after clear", 32'(irq), 32'd0);
      rd(3'd5, d); chk("R11 unmapped", d, 32'd0);
      @(negedge clk); chk("R11 idle rdata", bus_rdata, 32'd0);

      // R10 fill queue
      for (int i = 0; i < 8; i++) send(32'h5000_0000 + 32'(i), i == 0, i == 7);
      chk("R10 ready low when full", 32'(rx_ready), 32'd0);
      send(32'hDEAD_BEEF, 1'b1, 1'b1);
      for (int p = 0; p < 4; p++) begin
         rd(3'd0, d); chk("R10 full status", d, {30'd0, p == 3, p == 0});
         rd(3'd1, d); chk("R10 full lo", d, 32'h5000_0000 + 32'(2 * p));
         rd(3'd2, d); chk("R10 full hi", d, 32'h5000_0001 + 32'(2 * p));
      end
      rd(3'd0, d); chk("R10 refused dword absent", d, 32'd0);
      chk("R10 ready restored", 32'(rx_ready), 32'd1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule